// File: doc/BRIEF.md
# Addressed Audio Playout Buffer

This block sits behind a byte receiver on a shared medium where every station hears every packet. It scans the incoming byte stream for packet headers. It keeps the payload of packets addressed to the local station and throws away everything else. Accepted samples queue in an internal FIFO. The block acts as a jitter buffer: the DAC stays silent until enough samples have built up. After that, one 8-bit sample goes out on each tick of the selected playback rate.

A packet is the start byte 0xA5, then one ID byte, then exactly `PAYLOAD` sample bytes (8 by default). In the ID byte, bits 5:3 hold the destination station and bits 2:0 hold the sender. The block keeps the sender ID of the most recent accepted packet on an output so that it can be displayed. The playback tick comes from the clock: a base tick occurs every `TICK_CYCLES` cycles and gives the fast rate, and the slow rate uses every second base tick. At 125 MHz, the default of 31250 cycles gives 4 kHz and 2 kHz.

Top module: `audio_rx_playout`

## Requirements
- R1: After reset, the FIFO is empty, `last_src` is 0, `playing` is 0, `dac_strobe` is 0 and `dac_data` is midscale, 0x80.
- R2: Outside a packet, any byte other than 0xA5 is ignored. The byte after 0xA5 is the ID byte, with the destination in bits 5:3 and the sender in bits 2:0. The ID byte is followed by exactly `PAYLOAD` payload bytes, and inside that count a payload byte equal to 0xA5 is treated as data.
- R3: When the destination field differs from `station_id`, the ID byte and the following `PAYLOAD` bytes are discarded. Nothing is written to the FIFO and `last_src` is unchanged.
- R4: The payload bytes of a packet addressed to this station enter the FIFO. They leave on `dac_data`, one per `dac_strobe` pulse, in arrival order.
- R5: While `playing` is 0, no sample is output. `playing` rises only after the FIFO holds at least `THRESH` samples (default 16).
- R6: When `rate_sel` is 2'b01, samples are output every `TICK_CYCLES` cycles. For every other `rate_sel` value, the interval is 2*`TICK_CYCLES` cycles.
- R7: If a playback tick finds the FIFO empty, `playing` drops and `dac_data` holds its last value. Output resumes only once the FIFO again reaches `THRESH`.
- R8: A payload byte that arrives while the FIFO holds `DEPTH` samples is dropped. The samples already in the FIFO are kept.
- R9: When a packet has started and no byte arrives for 256 cycles, the packet is aborted and the parser waits for a new 0xA5. Bytes already buffered stay in the FIFO. A gap shorter than 256 cycles does not abort the packet.
- R10: On an ID byte whose destination matches, `last_src` takes the sender field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_valid | input | 1 | One-cycle strobe for a received byte |
| rx_byte | input | 8 | Received byte |
| station_id | input | 3 | Local station ID |
| rate_sel | input | 2 | Playback rate; 01 fast, others slow |
| dac_data | output | 8 | Sample to the DAC |
| dac_strobe | output | 1 | One-cycle pulse when `dac_data` takes a new sample |
| playing | output | 1 | Playback active |
| last_src | output | 3 | Sender of the last accepted packet |

## Verification
A parser left in the wrong state shows at the ports within one packet. Payload bytes become misaligned, or foreign bytes are taken, and the next `dac_strobe` after the buffer drains carries a sample that differs from the one expected. A wrong fill count or `playing` flag shows as strobes before the threshold is reached, or after an underflow. It can also show as strobes missing, and strobe counts checked within a few playback ticks catch any of these. A wrong rate divider changes the gap between two consecutive strobes. A missing timeout shifts every later sample by the number of bytes of the broken packet.

// File: rtl/audio_rx_playout.sv
module audio_rx_playout #(
  parameter int DEPTH       = 32,
  parameter int THRESH      = 16,
  parameter int PAYLOAD     = 8,
  parameter int TICK_CYCLES = 31250,
  parameter int TIMEOUT     = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic [2:0] station_id,
  input  logic [1:0] rate_sel,
  output logic [7:0] dac_data,
  output logic       dac_strobe,
  output logic       playing,
  output logic [2:0] last_src
);
  localparam int AW = $clog2(DEPTH);
  localparam int BW = $clog2(PAYLOAD + 1);
  localparam int IW = $clog2(TIMEOUT + 1);
  localparam int TW = $clog2(TICK_CYCLES + 1);

  typedef enum logic [1:0] {P_IDLE, P_ID, P_TAKE, P_SKIP} pstate_t;

  pstate_t        st;
  logic [BW-1:0]  bcnt;
  logic [IW-1:0]  idle_cnt;
  logic [7:0]     mem [DEPTH];
  logic [AW-1:0]  wptr, rptr;
  logic [AW:0]    fill;
  logic [TW-1:0]  tcnt;
  logic           phase;

  wire full   = (fill == (AW+1)'(DEPTH));
  wire wr     = rx_valid && (st == P_TAKE) && !full;
  wire base   = (tcnt == TW'(TICK_CYCLES - 1));
  wire tick   = base && ((rate_sel == 2'b01) || phase);
  wire rd     = tick && playing && (fill != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= P_IDLE;
      bcnt     <= '0;
      idle_cnt <= '0;
      last_src <= '0;
    end else if (rx_valid) begin
      idle_cnt <= '0;
      case (st)
        P_IDLE: if (rx_byte == 8'hA5) st <= P_ID;
        P_ID: begin
          bcnt <= '0;
          if (rx_byte[5:3] == station_id) begin
            st       <= P_TAKE;
            last_src <= rx_byte[2:0];
          end else begin
            st <= P_SKIP;
          end
        end
        default: begin
          bcnt <= bcnt + 1'b1;
          if (bcnt == BW'(PAYLOAD - 1)) st <= P_IDLE;
        end
      endcase
    end else if (st != P_IDLE) begin
      if (idle_cnt == IW'(TIMEOUT - 1)) begin
        st       <= P_IDLE;
        idle_cnt <= '0;
      end else begin
        idle_cnt <= idle_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr) mem[wptr] <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
    end else begin
      if (wr) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (rd) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      fill <= fill + (AW+1)'(wr) - (AW+1)'(rd);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt  <= '0;
      phase <= 1'b0;
    end else if (base) begin
      tcnt  <= '0;
      phase <= ~phase;
    end else begin
      tcnt <= tcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      playing    <= 1'b0;
      dac_data   <= 8'h80;
      dac_strobe <= 1'b0;
    end else begin
      dac_strobe <= rd;
      if (rd) dac_data <= mem[rptr];
      if (!playing && fill >= (AW+1)'(THRESH)) playing <= 1'b1;
      else if (playing && tick && fill == '0) playing <= 1'b0;
    end
  end
endmodule

// File: rtl/audio_rx_playout_chk.sv
module audio_rx_playout_chk #(
  parameter int DEPTH  = 32,
  parameter int THRESH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       rx_valid,
  input logic                       dac_strobe,
  input logic [7:0]                 dac_data,
  input logic                       playing,
  input logic [2:0]                 last_src,
  input logic [$clog2(DEPTH):0]     fill
);
  localparam int CW = $clog2(DEPTH) + 1;

  AST_RESET_MIDSCALE: assert property (@(posedge clk) !rst_n |=> (dac_data == 8'h80 && !playing)); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) fill <= CW'(DEPTH)); // R8
  AST_START_AT_THRESH: assert property (@(posedge clk) disable iff (!rst_n) $rose(playing) |-> $past(fill) >= CW'(THRESH)); // R5
  AST_STROBE_NEEDS_PLAY: assert property (@(posedge clk) disable iff (!rst_n) dac_strobe |-> $past(playing)); // R5
  AST_DAC_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !dac_strobe |-> $stable(dac_data)); // R7
  AST_SRC_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n) !rx_valid |=> $stable(last_src)); // R10
endmodule

bind audio_rx_playout audio_rx_playout_chk #(.DEPTH(DEPTH), .THRESH(THRESH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .dac_strobe(dac_strobe),
  .dac_data(dac_data), .playing(playing), .last_src(last_src), .fill(fill)
);

// File: tb/audio_rx_playout_test.sv
`timescale 1ns/1ps
module audio_rx_playout_test;
  localparam int DEPTH = 32, THRESH = 16, PAYLOAD = 8, TICK = 16;
  localparam logic [2:0] ME = 3'd5;

  logic clk = 0, rst_n = 0, rx_valid = 0;
  logic [7:0] rx_byte = 0;
  logic [1:0] rate_sel = 2'b01;
  logic [7:0] dac_data;
  logic dac_strobe, playing;
  logic [2:0] last_src;

  int checks = 0, errors = 0, nstrobe = 0, drops = 0;
  longint cyc = 0, prev_t = -1, last_iv = 0;
  logic [7:0] q[$];
  int mst = 0, mcnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  audio_rx_playout #(.DEPTH(DEPTH), .THRESH(THRESH), .PAYLOAD(PAYLOAD),
                     .TICK_CYCLES(TICK), .TIMEOUT(256)) uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .station_id(ME), .rate_sel(rate_sel), .dac_data(dac_data),
    .dac_strobe(dac_strobe), .playing(playing), .last_src(last_src));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] id_byte(input logic [2:0] d, input logic [2:0] s);
    return {2'b00, d, s};
  endfunction

  always @(posedge clk) begin
    #1;
    cyc++;
    if (rst_n && rx_valid) begin
      case (mst)
        0: if (rx_byte == 8'hA5) mst = 1;
        1: begin mcnt = 0; mst = (rx_byte[5:3] == ME) ? 2 : 3; end
        default: begin
          if (mst == 2) begin
            if (q.size() < DEPTH) q.push_back(rx_byte); else drops++;
          end
          mcnt++;
          if (mcnt == PAYLOAD) mst = 0;
        end
      endcase
    end
    if (rst_n && dac_strobe) begin
      nstrobe++;
      if (prev_t >= 0) last_iv = cyc - prev_t;
      prev_t = cyc;
      if (q.size() == 0) chk(0, "R4 strobe with empty model", dac_data, -1);
      else begin
        logic [7:0] e;
        e = q.pop_front();
        chk(dac_data == e, "R4 sample order", dac_data, e);
      end
    end
  end

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_byte = b;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
    if (n >= 256) mst = 0;
  endtask

  task automatic send_pkt(input logic [2:0] d, input logic [2:0] s, input bit with_a5);
    send_byte(8'hA5);
    send_byte(id_byte(d, s));
    for (int i = 0; i < PAYLOAD; i++)
      send_byte((with_a5 && i[0]) ? 8'hA5 : 8'($urandom));
  endtask

  task automatic drain();
    int t = 0;
    while (q.size() != 0 && t < 5000) begin @(negedge clk); t++; end
    gap(4 * TICK + 4);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    logic [7:0] held;
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    chk(dac_data == 8'h80, "R1 dac midscale", dac_data, 8'h80);
    chk(playing == 0, "R1 playing", playing, 0);
    chk(last_src == 0, "R1 last_src", last_src, 0);
    chk(dac_strobe == 0, "R1 strobe", dac_strobe, 0);
    rst_n = 1;
    gap(2);

    // R2: idle noise then one addressed packet
    send_byte(8'h12); send_byte(8'h00); send_byte(id_byte(ME, 3'd7));
    send_pkt(ME, 3'd2, 1);
    gap(200);
    chk(last_src == 3'd2, "R10 last_src update", last_src, 2);
    chk(nstrobe == 0, "R5 below threshold", nstrobe, 0);
    chk(playing == 0, "R5 not playing", playing, 0);

    // R3: foreign packet with embedded start bytes
    send_pkt(3'd1, 3'd6, 1);
    gap(200);
    chk(last_src == 3'd2, "R3 last_src kept", last_src, 2);
    chk(nstrobe == 0, "R3 no foreign fill", nstrobe, 0);

    // reach threshold, fast rate
    send_pkt(ME, 3'd4, 0);
    gap(8 * TICK);
    chk(playing == 1, "R5 playing after threshold", playing, 1);
    chk(last_iv == TICK, "R6 fast interval", last_iv, TICK);
    drain();
    chk(nstrobe == 16, "R4 all samples out", nstrobe, 16);
    chk(playing == 0, "R7 stop on empty", playing, 0);
    held = dac_data;

    // R7: under threshold after underflow
    send_pkt(ME, 3'd4, 0);
    gap(400);
    chk(nstrobe == 16, "R7 wait threshold again", nstrobe, 16);
    chk(dac_data == held, "R7 hold last value", dac_data, held);

    // R6 slow rate
    rate_sel = 2'b00;
    send_pkt(ME, 3'd3, 0);
    gap(8 * TICK);
    chk(last_iv == 2 * TICK, "R6 slow interval", last_iv, 2 * TICK);
    drain();
    chk(nstrobe == 32, "R7 resumed count", nstrobe, 32);

    // R9 timeout abort and short gap tolerance
    rate_sel = 2'b01;
    send_byte(8'hA5); send_byte(id_byte(ME, 3'd1));
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
    gap(300);
    send_byte(8'hA5); send_byte(id_byte(ME, 3'd6));
    for (int i = 0; i < 4; i++) send_byte(8'(8'h40 + i));
    gap(200);
    for (int i = 0; i < 4; i++) send_byte(8'(8'h50 + i));
    send_pkt(ME, 3'd6, 0);
    drain();
    chk(nstrobe == 32 + 19, "R9 timeout and short gap", nstrobe, 32 + 19);
    chk(last_src == 3'd6, "R10 last sender", last_src, 6);

    // R8 overflow: slow drain, fast fill
    rate_sel = 2'b10;
    base = nstrobe;
    for (int p = 0; p < 6; p++) send_pkt(ME, 3'd0, 0);
    chk(drops > 0, "R8 overflow produced", drops, 1);
    drain();
    chk(nstrobe - base == 48 - drops, "R8 drop count", nstrobe - base, 48 - drops);

    // random traffic
    rate_sel = 2'b01;
    for (int p = 0; p < 40; p++) begin
      logic [2:0] d;
      d = ($urandom % 2) ? ME : 3'($urandom % 5);
      if ($urandom % 4 == 0) send_byte(8'($urandom % 160));
      send_pkt(d, 3'($urandom), $urandom % 2);
      gap($urandom % 4);
      if (q.size() > 24) drain();
    end
    drain();
    chk(q.size() == 0, "R4 random drained", q.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule